// File: doc/BRIEF.md
# Zone Write Protection Filter

This block stands between a command decoder and the write port of a byte-wide nonvolatile user zone. Each accepted request carries a start address, up to one window of data bytes, a byte count and the protection mode of the target zone. Alongside the request, the caller supplies the current contents of the aligned 16-byte window that holds the start address. One clock later the block presents per-byte write strobes and the data to store for that window, or a rejection.

The zone can be in one of four modes:

- **Open:** the bytes pass unchanged.
- **Clear-only:** each stored byte is the old value ANDed with the new one, so bits can only fall from 1 to 0.
- **Frozen:** every write is turned away.
- **Page-locked:** each 8-byte half of the window opens with a guard byte whose bits gate the bytes of that half. Only the first byte of a request is kept in this mode. The guard byte itself may only lose bits.

Top module: `wp_filter`

## Requirements
- R1: While reset is asserted and after its release with no request, `wr_valid`, `wr_reject`, `wr_strobe` and `wr_data` are all zero.
- R2: A request sampled with `req_valid` high at a rising edge produces `wr_valid` high for the cycle after that edge. Without a request, `wr_valid` is low and no strobe is raised.
- R3: In open mode (`zone_mode`=2'b00), a request with count 1..16 that stays inside the window raises `wr_strobe[j]` for offsets j = `req_addr[3:0]` .. `req_addr[3:0]`+count-1. Request byte i (bits 8i+7:8i of `req_data`) appears unchanged in lane `req_addr[3:0]`+i of `wr_data`, and `wr_page` equals `req_addr[6:4]`.
- R4: In open or clear-only mode, a request is rejected if its count is 0, its count is above 16, or `req_addr[3:0]`+count exceeds 16.
- R5: In clear-only mode (2'b10), each strobed lane carries the old byte ANDed with the new byte.
- R6: In frozen mode (2'b11), every request is rejected.
- R7: In page-locked mode (2'b01), at most the first request byte is written, at lane `req_addr[3:0]`. The remaining bytes are dropped without rejection.
- R8: In page-locked mode, the guard byte is the old byte at window offset `req_addr[3]`*8. For an offset k = `req_addr[2:0]` from 1 to 7, the write proceeds with the new byte unchanged if guard bit k is 1, and is rejected if that bit is 0.
- R9: In page-locked mode with k = 0, the target is the guard byte itself. The write is rejected if its bit 0 is 0; otherwise the stored value is the old guard ANDed with the new byte.
- R10: A rejected request raises no strobe. Lanes without a strobe carry zero data. A page-locked request with count 0 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present this cycle |
| req_addr | input | 7 | Start byte address inside the zone |
| req_count | input | 5 | Number of request bytes |
| req_data | input | 128 | Request bytes, byte i at bits 8i+7:8i |
| zone_mode | input | 2 | 00 open, 01 page-locked, 10 clear-only, 11 frozen |
| old_data | input | 128 | Current contents of the 16-byte window holding req_addr, offset j at bits 8j+7:8j |
| wr_valid | output | 1 | Filtered result present |
| wr_reject | output | 1 | Request refused |
| wr_strobe | output | 16 | Per-lane write strobe for the window |
| wr_page | output | 3 | Window index within the zone |
| wr_data | output | 128 | Data to store, per lane |

## Verification
Every result is registered once, so strobes, data, page and the reject flag belong to the request sampled at the previous rising edge and hold for exactly one cycle. Each scenario task drives its request on a falling edge and drops `req_valid` on the next falling edge. It samples all outputs at that same moment, which lies half a cycle after the capturing edge. A separate idle check confirms that nothing is presented in the cycle after a quiet edge.

// File: rtl/wp_filter_pkg.sv
package wp_filter_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ZM_OPEN       = 2'b00,
        ZM_PAGE_LOCK  = 2'b01,
        ZM_CLEAR_ONLY = 2'b10,
        ZM_FROZEN     = 2'b11
    } zone_mode_e;

endpackage

// File: rtl/wp_span.sv
module wp_span #(
    parameter int WIN_BYTES = 16,
    parameter int OFF_W     = 4,
    parameter int CNT_W     = 5
) (
    input  logic [OFF_W-1:0]     off,
    input  logic [CNT_W-1:0]     count,
    output logic [WIN_BYTES-1:0] lane_in_span,
    output logic                 span_ok
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = SUM_W'(off) + SUM_W'(count);
        span_ok  = (count != '0)
                && (SUM_W'(count) <= SUM_W'(WIN_BYTES))
                && (span_end <= SUM_W'(WIN_BYTES));
    end

    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_lane
        always_comb begin
            lane_in_span[j] = (SUM_W'(j) >= SUM_W'(off)) && (SUM_W'(j) < span_end);
        end
    end

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
    parameter int WIN_BYTES  = 16,
    parameter int LOCK_BYTES = 8,
    parameter int OFF_W      = 4,
    parameter int BYTE_W     = 8
) (
    input  logic [OFF_W-1:0]            off,
    input  logic [WIN_BYTES*BYTE_W-1:0] old_win,
    output logic                        guard_open,
    output logic                        on_guard
);
    localparam int LOCK_W = $clog2(LOCK_BYTES);

    logic [OFF_W-1:0]  guard_off;
    logic [BYTE_W-1:0] guard_byte;
    logic [LOCK_W-1:0] k;

    always_comb begin
        guard_off  = off & ~OFF_W'(LOCK_BYTES - 1);
        guard_byte = old_win[32'(guard_off) * BYTE_W +: BYTE_W];
        k          = off[LOCK_W-1:0];
        guard_open = guard_byte[k];
        on_guard   = (k == '0);
    end

endmodule

// File: rtl/wp_lane.sv
module wp_lane
    import wp_filter_pkg::*;
(
    input  zone_mode_e        mode,
    input  logic              in_span,
    input  logic              is_first,
    input  logic              on_guard,
    input  logic [BYTE_W-1:0] new_b,
    input  logic [BYTE_W-1:0] old_b,
    output logic              stb,
    output logic [BYTE_W-1:0] dat
);
    logic [BYTE_W-1:0] raw;

    always_comb begin
        stb = 1'b0;
        raw = new_b;
        unique case (mode)
            ZM_OPEN: begin
                stb = in_span;
                raw = new_b;
            end
            ZM_CLEAR_ONLY: begin
                stb = in_span;
                raw = old_b & new_b;
            end
            ZM_PAGE_LOCK: begin
                stb = is_first;
                raw = on_guard ? (old_b & new_b) : new_b;
            end
            default: begin
                stb = 1'b0;
                raw = '0;
            end
        endcase
        dat = stb ? raw : '0;
    end

endmodule

// File: rtl/wp_filter.sv
module wp_filter
    import wp_filter_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int WIN_BYTES  = 16,
    parameter int LOCK_BYTES = 8,
    localparam int OFF_W     = $clog2(WIN_BYTES),
    localparam int CNT_W     = $clog2(WIN_BYTES) + 1,
    localparam int PAGE_W    = ADDR_W - OFF_W,
    localparam int WIN_W     = WIN_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [WIN_W-1:0]  req_data,
    input  logic [1:0]        zone_mode,
    input  logic [WIN_W-1:0]  old_data,
    output logic              wr_valid,
    output logic              wr_reject,
    output logic [WIN_BYTES-1:0] wr_strobe,
    output logic [PAGE_W-1:0] wr_page,
    output logic [WIN_W-1:0]  wr_data
);

    typedef struct packed {
        logic                 valid;
        logic                 reject;
        logic [WIN_BYTES-1:0] strobe;
        logic [PAGE_W-1:0]    page;
        logic [WIN_W-1:0]     data;
    } out_st_t;

    out_st_t st_d, st_q;

    zone_mode_e           mode;
    logic [OFF_W-1:0]     off;
    logic [WIN_W-1:0]     aligned;
    logic [WIN_BYTES-1:0] in_span;
    logic                 span_ok;
    logic                 guard_open;
    logic                 on_guard;
    logic [WIN_BYTES-1:0] lane_stb;
    logic [WIN_W-1:0]     lane_dat;
    logic                 refuse;

    always_comb begin
        mode    = zone_mode_e'(zone_mode);
        off     = req_addr[OFF_W-1:0];
        aligned = req_data << (32'(off) * BYTE_W);
    end

    wp_span #(
        .WIN_BYTES(WIN_BYTES),
        .OFF_W    (OFF_W),
        .CNT_W    (CNT_W)
    ) i_span (
        .off         (off),
        .count       (req_count),
        .lane_in_span(in_span),
        .span_ok     (span_ok)
    );

    wp_guard #(
        .WIN_BYTES (WIN_BYTES),
        .LOCK_BYTES(LOCK_BYTES),
        .OFF_W     (OFF_W),
        .BYTE_W    (BYTE_W)
    ) i_guard (
        .off       (off),
        .old_win   (old_data),
        .guard_open(guard_open),
        .on_guard  (on_guard)
    );

    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_lanes
        wp_lane i_lane (
            .mode    (mode),
            .in_span (in_span[j]),
            .is_first(off == OFF_W'(j)),
            .on_guard(on_guard),
            .new_b   (aligned[j*BYTE_W +: BYTE_W]),
            .old_b   (old_data[j*BYTE_W +: BYTE_W]),
            .stb     (lane_stb[j]),
            .dat     (lane_dat[j*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        unique case (mode)
            ZM_OPEN, ZM_CLEAR_ONLY: refuse = !span_ok;
            ZM_PAGE_LOCK:           refuse = (req_count == '0) || !guard_open;
            default:                refuse = 1'b1;
        endcase

        st_d        = '0;
        st_d.valid  = req_valid;
        st_d.page   = req_valid ? req_addr[ADDR_W-1:OFF_W] : '0;
        if (req_valid) begin
            st_d.reject = refuse;
            st_d.strobe = refuse ? '0 : lane_stb;
            st_d.data   = refuse ? '0 : lane_dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid  = st_q.valid;
    assign wr_reject = st_q.reject;
    assign wr_strobe = st_q.strobe;
    assign wr_page   = st_q.page;
    assign wr_data   = st_q.data;

    // R2: a result follows each request by one cycle, and only then
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> wr_valid);
    a_r2_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wr_valid && wr_strobe == '0));

    // R10: refused requests never strobe memory
    a_r10_reject_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> (wr_strobe == '0));

    // R6: frozen zones refuse everything
    a_r6_frozen_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && zone_mode == ZM_FROZEN) |=> wr_reject);

    // R7: page-locked writes touch at most one lane
    a_r7_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && zone_mode == ZM_PAGE_LOCK) |=> ($countones(wr_strobe) <= 1));

    // R4: a span leaving the window is refused in open mode
    a_r4_span_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && zone_mode == ZM_OPEN
         && ({1'b0, req_addr[OFF_W-1:0]} + (OFF_W+1)'(req_count)) > (OFF_W+1)'(WIN_BYTES))
        |=> wr_reject);

    // R5: clear-only lanes never raise a bit that was 0
    for (genvar j = 0; j < WIN_BYTES; j++) begin : g_chk
        a_r5_no_bit_raised: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && zone_mode == ZM_CLEAR_ONLY) |=>
            ((wr_data[j*BYTE_W +: BYTE_W] & ~$past(old_data[j*BYTE_W +: BYTE_W])) == '0));
    end

endmodule

// File: tb/test_wp_filter.sv
module test_wp_filter;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [6:0]   req_addr = '0;
    logic [4:0]   req_count = '0;
    logic [W-1:0] req_data = '0;
    logic [1:0]   zone_mode = '0;
    logic [W-1:0] old_data = '0;
    logic         wr_valid, wr_reject;
    logic [15:0]  wr_strobe;
    logic [2:0]   wr_page;
    logic [W-1:0] wr_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wp_filter i_wp_filter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .req_data(req_data), .zone_mode(zone_mode),
        .old_data(old_data), .wr_valid(wr_valid), .wr_reject(wr_reject),
        .wr_strobe(wr_strobe), .wr_page(wr_page), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive on a falling edge, leave at the next one and sample there
    task automatic send(input logic [1:0] m, input logic [6:0] a, input logic [4:0] n,
                        input logic [W-1:0] d, input logic [W-1:0] o);
        @(negedge clk);
        zone_mode = m; req_addr = a; req_count = n; req_data = d; old_data = o;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic rej, input logic [15:0] stb,
                              input logic [W-1:0] dat);
        chk({tag, " valid"}, W'(wr_valid), W'(1'b1));
        chk({tag, " reject"}, W'(wr_reject), W'(rej));
        chk({tag, " strobe"}, W'(wr_strobe), W'(stb));
        chk({tag, " data"}, wr_data, dat);
    endtask

    task automatic t_reset;
        chk("R1 valid", W'(wr_valid), '0);
        chk("R1 reject", W'(wr_reject), '0);
        chk("R1 strobe", W'(wr_strobe), '0);
        chk("R1 data", wr_data, '0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle valid", W'(wr_valid), '0);
        chk("R2 idle strobe", W'(wr_strobe), '0);
    endtask

    task automatic t_open;
        send(2'b00, 7'h15, 5'd1, W'(8'hA5), '0);
        expect_out("R3 single", 1'b0, 16'h0020, W'(8'hA5) << 40);
        chk("R3 page", W'(wr_page), W'(3'd1));
        send(2'b00, 7'h20, 5'd16, 128'h100F0E0D0C0B0A090807060504030201, '1);
        expect_out("R3 full", 1'b0, 16'hFFFF, 128'h100F0E0D0C0B0A090807060504030201);
        chk("R3 page full", W'(wr_page), W'(3'd2));
    endtask

    task automatic t_span_reject;
        send(2'b00, 7'h0E, 5'd3, W'(24'h332211), '0);
        expect_out("R4 cross", 1'b1, 16'h0000, '0);
        send(2'b00, 7'h00, 5'd0, W'(8'h11), '0);
        expect_out("R4 zero", 1'b1, 16'h0000, '0);
        send(2'b00, 7'h00, 5'd17, '1, '0);
        expect_out("R4 over", 1'b1, 16'h0000, '0);
        send(2'b10, 7'h0F, 5'd2, W'(16'h0101), '1);
        expect_out("R4 clear-only cross", 1'b1, 16'h0000, '0);
    endtask

    task automatic t_clear_only;
        send(2'b10, 7'h33, 5'd2, W'(16'hFF3C), W'(16'h0FF0) << 24);
        expect_out("R5 and", 1'b0, 16'h0018, W'(16'h0F30) << 24);
    endtask

    task automatic t_frozen;
        send(2'b11, 7'h40, 5'd1, W'(8'h00), '1);
        expect_out("R6 frozen", 1'b1, 16'h0000, '0);
    endtask

    task automatic t_page_lock;
        // guard at offset 8 = 0x08 opens offset 11 (k=3); old lane 11 = FF
        send(2'b01, 7'h0B, 5'd4, W'(32'h44332212), (W'(8'h08) << 64) | (W'(8'hFF) << 88));
        expect_out("R7 R8 first only", 1'b0, 16'h0800, W'(8'h12) << 88);
        // guard at offset 0 = FB closes offset 2
        send(2'b01, 7'h42, 5'd1, W'(8'h55), W'(8'hFB));
        expect_out("R8 locked", 1'b1, 16'h0000, '0);
        // guard byte write, bit 0 open
        send(2'b01, 7'h08, 5'd1, W'(8'h0F), W'(8'hF1) << 64);
        expect_out("R9 guard and", 1'b0, 16'h0100, W'(8'h01) << 64);
        // guard byte sealed by bit 0
        send(2'b01, 7'h08, 5'd1, W'(8'hFF), W'(8'hFE) << 64);
        expect_out("R9 guard sealed", 1'b1, 16'h0000, '0);
        send(2'b01, 7'h0B, 5'd0, W'(8'h12), W'(8'h08) << 64);
        expect_out("R10 zero count", 1'b1, 16'h0000, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_open();
        t_span_reject();
        t_clear_only();
        t_frozen();
        t_page_lock();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule